// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches page translations for a processor core. It has one direct-mapped table with a single shared slot per index that holds the physical page number. Three independent tag arrays sit over that slot: one for instruction fetches, one for loads and one for stores. A lookup names an access type and a virtual page number (VPN). The tag of that type at the selected index decides hit or miss, and the shared slot supplies the physical page number.

After a successful page walk, the refill port installs a translation. Only the tag of the refill's access type is written. A sibling tag at the same index that belongs to a different page is knocked out, because the shared slot now belongs to the new page. Each tag carries a trigger-check flag. When the flag is set, a matching lookup is turned away to the slow path. A flush invalidates everything. There is no state machine: every operation completes in the cycle it is presented, and the lookup result is registered.

Access type encoding on both ports: 0 = fetch, 1 = load, 2 = store. Code 3 matches no tag array.

Top module: `tlb_split_tag`

## Requirements
- R1: After reset every tag is invalid (all ones), so any lookup misses, and `rsp_valid_o` is low until a lookup is made.
- R2: The index is the VPN modulo `ENTRIES` (its low bits), and the tag holds the whole VPN. A lookup of a different VPN that shares the index misses.
- R3: `rsp_valid_o` is high in exactly the cycle after a cycle with `lk_valid_i` high, and is low otherwise.
- R4: A lookup hits when the tag of its access type at the index equals the VPN with the flag clear. The hit returns the shared slot's physical page number.
- R5: Each access type has its own tag. A refill of one type does not make another type hit.
- R6: The physical page number is shared. A refill of any type at an index overwrites the value that every hitting type returns.
- R7: On a refill, a sibling tag at the same index whose VPN (flag ignored) differs from the refill VPN becomes invalid.
- R8: On a refill, a sibling tag whose VPN equals the refill VPN is kept unchanged, including its flag.
- R9: When `trig_en_i[type]` is high (bit 0 fetch, bit 1 load, bit 2 store) during a refill, the stored tag has its flag set. A later lookup that matches it reports miss with `rsp_slow_o` high.
- R10: A flush invalidates all tags of all three types. A flush takes priority over a refill presented in the same cycle.
- R11: When a lookup and a refill address the same index in one cycle, the lookup reports the contents from before the refill.
- R12: `rsp_hit_o` and `rsp_slow_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all tags |
| lk_valid_i | input | 1 | Lookup request |
| lk_type_i | input | 2 | Lookup access type |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| rf_valid_i | input | 1 | Refill request |
| rf_type_i | input | 2 | Refill access type |
| rf_vpn_i | input | VPN_W | Refill virtual page number |
| rf_ppn_i | input | PPN_W | Refill physical page number |
| trig_en_i | input | 3 | Trigger-check enable per access type |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_slow_o | output | 1 | Tag matched but flagged for slow path |
| rsp_ppn_o | output | PPN_W | Physical page number from the shared slot |

## Verification
Refills and flushes change the arrays at the clock edge where they are presented. A lookup result appears on the outputs one edge after its request. The bench applies each operation on a falling edge and samples the response on the next falling edge, which is after exactly one rising edge. The next operation starts only after that sample. The same-cycle case in R11 presents a lookup and a refill together, then checks the old contents at that sample and the new contents with a second lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int unsigned NUM_ACC = 3;
endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VPN_W   = 20,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             rf_en_i,
    input  logic [IDX_W-1:0] rf_idx_i,
    input  logic [VPN_W-1:0] rf_vpn_i,
    input  logic             wr_en_i,
    input  logic             wr_flag_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0] rd_tag_o
);
    // bit VPN_W is the trigger-check flag, low bits are the VPN
    logic [TAG_W-1:0] tag_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '1;
        end else if (flush_i) begin
            for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '1;
        end else if (rf_en_i) begin
            if (wr_en_i)
                tag_q[rf_idx_i] <= {wr_flag_i, rf_vpn_i};
            else if (tag_q[rf_idx_i][VPN_W-1:0] != rf_vpn_i)
                tag_q[rf_idx_i] <= '1;
        end
    end

    assign rd_tag_o = tag_q[rd_idx_i];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        AST_FLUSH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
            flush_i |=> (&tag_q[e])); // R10
    end

    AST_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en_i && wr_en_i && !flush_i) |=>
        tag_q[$past(rf_idx_i)] == {$past(wr_flag_i), $past(rf_vpn_i)}); // R9

    AST_SIBLING_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en_i && !wr_en_i && !flush_i) |=>
        ((&tag_q[$past(rf_idx_i)]) ||
         tag_q[$past(rf_idx_i)][VPN_W-1:0] == $past(rf_vpn_i))); // R7
endmodule

// File: rtl/tlb_data_bank.sv
module tlb_data_bank #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PPN_W   = 22,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PPN_W-1:0] wr_ppn_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PPN_W-1:0] rd_ppn_o
);
    logic [PPN_W-1:0] slot_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) slot_q[e] <= '0;
        end else if (wr_en_i) begin
            slot_q[wr_idx_i] <= wr_ppn_i;
        end
    end

    assign rd_ppn_o = slot_q[rd_idx_i];

    AST_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> slot_q[$past(wr_idx_i)] == $past(wr_ppn_i)); // R6
endmodule

// File: rtl/tlb_split_tag.sv
module tlb_split_tag
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             lk_valid_i,
    input  logic [1:0]       lk_type_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    input  logic             rf_valid_i,
    input  logic [1:0]       rf_type_i,
    input  logic [VPN_W-1:0] rf_vpn_i,
    input  logic [PPN_W-1:0] rf_ppn_i,
    input  logic [2:0]       trig_en_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_slow_o,
    output logic [PPN_W-1:0] rsp_ppn_o
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_W = VPN_W + 1;

    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] bank_tag [NUM_ACC];
    logic [TAG_W-1:0] sel_tag;
    logic [PPN_W-1:0] slot_ppn;
    logic             hit_d, slow_d;

    assign lk_idx = lk_vpn_i[IDX_W-1:0];
    assign rf_idx = rf_vpn_i[IDX_W-1:0];

    for (genvar b = 0; b < NUM_ACC; b++) begin : g_bank
        tlb_tag_bank #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (flush_i),
            .rf_en_i  (rf_valid_i),
            .rf_idx_i (rf_idx),
            .rf_vpn_i (rf_vpn_i),
            .wr_en_i  (rf_type_i == 2'(b)),
            .wr_flag_i(trig_en_i[b]),
            .rd_idx_i (lk_idx),
            .rd_tag_o (bank_tag[b])
        );
    end

    tlb_data_bank #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (rf_valid_i && !flush_i),
        .wr_idx_i(rf_idx),
        .wr_ppn_i(rf_ppn_i),
        .rd_idx_i(lk_idx),
        .rd_ppn_o(slot_ppn)
    );

    always_comb begin
        unique case (acc_e'(lk_type_i))
            ACC_FETCH: sel_tag = bank_tag[0];
            ACC_LOAD:  sel_tag = bank_tag[1];
            ACC_STORE: sel_tag = bank_tag[2];
            default:   sel_tag = '1;
        endcase
        hit_d  = (lk_type_i != 2'd3) && (sel_tag == {1'b0, lk_vpn_i});
        slow_d = (lk_type_i != 2'd3) && sel_tag[VPN_W] &&
                 (sel_tag[VPN_W-1:0] == lk_vpn_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_hit_o   <= 1'b0;
            rsp_slow_o  <= 1'b0;
            rsp_ppn_o   <= '0;
        end else begin
            rsp_valid_o <= lk_valid_i;
            rsp_hit_o   <= lk_valid_i && hit_d;
            rsp_slow_o  <= lk_valid_i && slow_d;
            rsp_ppn_o   <= slot_ppn;
        end
    end

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> rsp_valid_o); // R3
    AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !rsp_valid_o); // R3
    AST_HIT_SLOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit_o && rsp_slow_o)); // R12
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> rsp_valid_o); // R4
endmodule

// File: tb/sim_tlb_split_tag.sv
`timescale 1ns/1ps
module sim_tlb_split_tag;
    localparam int VPN_W = 20;
    localparam int PPN_W = 22;

    logic clk = 1'b0, rst_n = 1'b0;
    logic flush_i = 0, lk_valid_i = 0, rf_valid_i = 0;
    logic [1:0] lk_type_i = 0, rf_type_i = 0;
    logic [VPN_W-1:0] lk_vpn_i = 0, rf_vpn_i = 0;
    logic [PPN_W-1:0] rf_ppn_i = 0;
    logic [2:0] trig_en_i = 0;
    logic rsp_valid_o, rsp_hit_o, rsp_slow_o;
    logic [PPN_W-1:0] rsp_ppn_o;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    tlb_split_tag u0 (.*);

    typedef struct packed {
        logic [1:0]  op;   // 0 lookup, 1 refill, 2 flush
        logic [1:0]  ty;
        logic        trig;
        logic [19:0] vpn;
        logic [21:0] ppn;
        logic        eh;
        logic        es;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 1'b0, 20'h00005, 22'h0,   1'b0, 1'b0, 4'd1 },  // R1 empty
        '{2'd1, 2'd0, 1'b0, 20'h00005, 22'h111, 1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd0, 1'b0, 20'h00005, 22'h111, 1'b1, 1'b0, 4'd4 },  // R4
        '{2'd0, 2'd1, 1'b0, 20'h00005, 22'h0,   1'b0, 1'b0, 4'd5 },  // R5
        '{2'd1, 2'd1, 1'b0, 20'h00005, 22'h222, 1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd0, 1'b0, 20'h00005, 22'h222, 1'b1, 1'b0, 4'd6 },  // R6
        '{2'd0, 2'd1, 1'b0, 20'h00005, 22'h222, 1'b1, 1'b0, 4'd6 },  // R6
        '{2'd0, 2'd0, 1'b0, 20'h00015, 22'h0,   1'b0, 1'b0, 4'd2 },  // R2
        '{2'd1, 2'd2, 1'b0, 20'h00015, 22'h333, 1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd0, 1'b0, 20'h00005, 22'h0,   1'b0, 1'b0, 4'd7 },  // R7
        '{2'd0, 2'd1, 1'b0, 20'h00005, 22'h0,   1'b0, 1'b0, 4'd7 },  // R7
        '{2'd0, 2'd2, 1'b0, 20'h00015, 22'h333, 1'b1, 1'b0, 4'd2 },  // R2
        '{2'd1, 2'd1, 1'b1, 20'h00007, 22'h444, 1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd1, 1'b0, 20'h00007, 22'h0,   1'b0, 1'b1, 4'd9 },  // R9
        '{2'd0, 2'd2, 1'b0, 20'h00015, 22'h333, 1'b1, 1'b0, 4'd2 },  // R2
        '{2'd2, 2'd0, 1'b0, 20'h00000, 22'h0,   1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd2, 1'b0, 20'h00015, 22'h0,   1'b0, 1'b0, 4'd10},  // R10
        '{2'd0, 2'd1, 1'b0, 20'h00007, 22'h0,   1'b0, 1'b0, 4'd10},  // R10
        '{2'd1, 2'd0, 1'b1, 20'h00009, 22'h666, 1'b0, 1'b0, 4'd0 },
        '{2'd1, 2'd1, 1'b0, 20'h00009, 22'h777, 1'b0, 1'b0, 4'd0 },
        '{2'd0, 2'd0, 1'b0, 20'h00009, 22'h0,   1'b0, 1'b1, 4'd8 },  // R8
        '{2'd0, 2'd1, 1'b0, 20'h00009, 22'h777, 1'b1, 1'b0, 4'd4 }   // R4
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic check_rsp(input bit eh, input bit es, input logic [21:0] ep, input int rq);
        check(rsp_valid_o === 1'b1, 3, "rsp_valid", 32'(rsp_valid_o), 1);   // R3
        check(rsp_hit_o === eh, rq, "hit", 32'(rsp_hit_o), 32'(eh));
        check(rsp_slow_o === es, rq, "slow", 32'(rsp_slow_o), 32'(es));
        if (eh) check(rsp_ppn_o === ep, rq, "ppn", 32'(rsp_ppn_o), 32'(ep));
        check(!(rsp_hit_o && rsp_slow_o), 12, "hit&slow", 32'(rsp_hit_o & rsp_slow_o), 0); // R12
    endtask

    task automatic idle_inputs();
        flush_i = 0; lk_valid_i = 0; rf_valid_i = 0; trig_en_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid_o === 1'b0, 1, "valid in reset", 32'(rsp_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid_o === 1'b0 && rsp_hit_o === 1'b0, 1, "idle after reset",
              32'({rsp_valid_o, rsp_hit_o}), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            unique case (v.op)
                2'd0: begin lk_valid_i = 1; lk_type_i = v.ty; lk_vpn_i = v.vpn; end
                2'd1: begin rf_valid_i = 1; rf_type_i = v.ty; rf_vpn_i = v.vpn;
                            rf_ppn_i = v.ppn; trig_en_i = v.trig ? (3'b001 << v.ty) : 3'b000; end
                default: flush_i = 1;
            endcase
            @(negedge clk);
            if (v.op == 2'd0) check_rsp(v.eh, v.es, v.ppn, int'(v.rq));
            else check(rsp_valid_o === 1'b0, 3, "no rsp without lookup", 32'(rsp_valid_o), 0); // R3
            idle_inputs();
        end

        // R11 same-cycle refill and lookup at one index
        rf_valid_i = 1; rf_type_i = 2'd0; rf_vpn_i = 20'h00003; rf_ppn_i = 22'hAAA;
        @(negedge clk); idle_inputs();
        rf_valid_i = 1; rf_type_i = 2'd0; rf_vpn_i = 20'h00013; rf_ppn_i = 22'hBBB;
        lk_valid_i = 1; lk_type_i = 2'd0; lk_vpn_i = 20'h00003;
        @(negedge clk); idle_inputs();
        check_rsp(1'b1, 1'b0, 22'hAAA, 11);
        lk_valid_i = 1; lk_type_i = 2'd0; lk_vpn_i = 20'h00003;
        @(negedge clk); idle_inputs();
        check_rsp(1'b0, 1'b0, 22'h0, 11);
        lk_valid_i = 1; lk_type_i = 2'd0; lk_vpn_i = 20'h00013;
        @(negedge clk); idle_inputs();
        check_rsp(1'b1, 1'b0, 22'hBBB, 11);

        // R10 flush beats simultaneous refill
        flush_i = 1; rf_valid_i = 1; rf_type_i = 2'd2; rf_vpn_i = 20'h00004; rf_ppn_i = 22'hCCC;
        @(negedge clk); idle_inputs();
        lk_valid_i = 1; lk_type_i = 2'd2; lk_vpn_i = 20'h00004;
        @(negedge clk); idle_inputs();
        check_rsp(1'b0, 1'b0, 22'h0, 10);
        lk_valid_i = 1; lk_type_i = 2'd0; lk_vpn_i = 20'h00013;
        @(negedge clk); idle_inputs();
        check_rsp(1'b0, 1'b0, 22'h0, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule